// File: doc/BRIEF.md
# Isochronous Cycle Timer With Master Mode

This block keeps the 8 kHz isochronous cycle time of a serial-bus link controller. Each rising clock edge is one tick of the 24.576 MHz timebase. A 12-bit offset counts ticks. When it rolls over, a 13-bit cycle number advances. While the node is both cycle master and bus root, every rollover also emits a one-cycle cycle-start request, which the packet builder downstream uses.

Three control bits govern the timer: enable, master and source. Software changes them through two write strobes. One strobe ORs the data into the register and the other clears the bits where the data is 1. Both addresses read back the same value. With master and source both set, the offset waits at its last value until a synchronized external sync edge arrives; an edge that comes earlier forces an early rollover. With master clear, received cycle-start times are loaded into the timer. A too-long-cycle fault drops master mode and keeps it down until the fault is acknowledged.

Top module: `cyc_timer_top`

## Requirements
- R1: A hardware reset (`rst` high at a clock edge) leaves the offset at 0, the count at 0, the control value at 0, the fault flag at 0 and `cycle_start` low.
- R2: Internal rollover: enable is bit 0 of the control value. While enable is 1 and external mode is not in effect, the offset rises by 1 on each clock. The edge after offset 3071 sets it to 0 and raises the count by 1.
- R3: While enable is 0 and no load occurs, the offset and count keep their values.
- R4: The count wraps from 8191 to 0 on rollover.
- R5: External mode is in effect when master (bit 1) and source (bit 2) are both 1. In this mode the offset stops at 3071 until a sync edge. A rising edge on `ext_sync` rolls the timer over (offset 0, count +1) on the third rising clock edge after `ext_sync` goes high, whatever the offset was.
- R6: While master is 0, the source bit has no effect: rollover is internal and `ext_sync` is ignored.
- R7: `cycle_start` is high for exactly the one cycle after a rollover, and only if master is 1 and `is_root` is 1 when the rollover occurs.
- R8: While master is 0, a `rx_load` pulse sets count and offset to `rx_count` and `rx_offset` at the next edge, whatever enable is. While master is 1, `rx_load` is ignored.
- R9: `ctl_set` ORs `ctl_wdata` into the control value and `ctl_clr` clears the bits where `ctl_wdata` is 1. When both are high in one cycle, the clear wins for the bits written. `ctl_rdata` always shows the control value as {source, master, enable}.
- R10: `too_long` clears master and sets `fault_flag`. While `fault_flag` is 1, a set write cannot set master. `fault_ack` clears `fault_flag`.
- R11: `soft_rst` clears enable and master and leaves source unchanged. A hardware reset clears source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24.576 MHz timebase clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| soft_rst | input | 1 | Software reset pulse |
| ctl_set | input | 1 | Set-address write strobe |
| ctl_clr | input | 1 | Clear-address write strobe |
| ctl_wdata | input | 3 | Write data {source, master, enable} |
| ctl_rdata | output | 3 | Control value {source, master, enable} |
| is_root | input | 1 | Node is bus root |
| ext_sync | input | 1 | Asynchronous external cycle sync |
| too_long | input | 1 | Cycle-too-long event pulse |
| fault_ack | input | 1 | Acknowledge of the too-long fault |
| fault_flag | output | 1 | Too-long fault pending |
| rx_load | input | 1 | Received cycle-start time valid |
| rx_count | input | 13 | Received cycle number |
| rx_offset | input | 12 | Received cycle offset |
| cycle_count | output | 13 | Cycle number |
| cycle_offset | output | 12 | Cycle offset |
| cycle_start | output | 1 | Cycle-start request pulse |

## Verification
The assertions assume that `rx_offset` stays at or below 3071, so the offset-range property holds after a load. They also assume that strobes are single-cycle pulses applied synchronously. The bench loads only legal offsets. It drives every strobe on the falling clock edge and holds it for one cycle. It raises `ext_sync` for several cycles, so the synchronizer sees a clean edge.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;
    localparam int OFF_W     = 12;
    localparam int CNT_W     = 13;
    localparam int CTL_W     = 3;
    localparam int TICKS_DEF = 3072;

    typedef struct packed {
        logic src;
        logic mst;
        logic en;
    } ctl_t;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [OFF_W-1:0] offset;
    } ctime_t;

    typedef enum logic [1:0] {
        ADV_HOLD,
        ADV_STEP,
        ADV_WRAP,
        ADV_LOAD
    } adv_e;

    function automatic ctl_t ctl_unpack(input logic [CTL_W-1:0] b);
        ctl_t c;
        c.en  = b[0];
        c.mst = b[1];
        c.src = b[2];
        return c;
    endfunction

    function automatic logic [CTL_W-1:0] ctl_pack(input ctl_t c);
        return {c.src, c.mst, c.en};
    endfunction
endpackage

// File: rtl/cyc_sync_edge.sv
module cyc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= async_in;
    end

    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[i] <= 1'b0;
            else     chain[i] <= chain[i-1];
        end
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/cyc_ctl_reg.sv
module cyc_ctl_reg
    import cyc_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             set_wr,
    input  logic             clr_wr,
    input  logic [CTL_W-1:0] wdata,
    input  logic             tl_evt,
    input  logic             tl_ack,
    output ctl_t             ctl,
    output logic             flag
);
    ctl_t ctl_nx;
    logic flag_nx;

    always_comb begin
        logic [CTL_W-1:0] bits;
        logic [CTL_W-1:0] setv;
        bits = ctl_pack(ctl);
        setv = wdata;
        if (flag) setv[1] = 1'b0;
        if (set_wr) bits = bits | setv;
        if (clr_wr) bits = bits & ~wdata;
        ctl_nx = ctl_unpack(bits);
        if (tl_evt) ctl_nx.mst = 1'b0;
        if (soft_rst) begin
            ctl_nx.en  = 1'b0;
            ctl_nx.mst = 1'b0;
        end
        if (tl_evt)      flag_nx = 1'b1;
        else if (tl_ack) flag_nx = 1'b0;
        else             flag_nx = flag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl  <= '0;
            flag <= 1'b0;
        end else begin
            ctl  <= ctl_nx;
            flag <= flag_nx;
        end
    end

    // R10
    master_block_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !ctl.mst) |=> !ctl.mst);
    // R10
    fault_drop_chk: assert property (@(posedge clk) disable iff (rst)
        tl_evt |=> (!ctl.mst && flag));
    // R11
    soft_keep_src_chk: assert property (@(posedge clk) disable iff (rst)
        (soft_rst && !set_wr && !clr_wr) |=> (ctl.src == $past(ctl.src) && !ctl.en && !ctl.mst));
endmodule

// File: rtl/cyc_offset_ctr.sv
module cyc_offset_ctr
    import cyc_timer_pkg::*;
#(
    parameter int TICKS = TICKS_DEF
) (
    input  logic   clk,
    input  logic   rst,
    input  ctl_t   ctl,
    input  logic   sync_rise,
    input  logic   is_root,
    input  logic   ld,
    input  ctime_t ld_time,
    output ctime_t now,
    output logic   cyc_start
);
    localparam logic [OFF_W-1:0] LAST = OFF_W'(TICKS - 1);

    adv_e adv;
    logic ext_mode;
    logic at_last;

    always_comb begin
        ext_mode = ctl.mst & ctl.src;
        at_last  = (now.offset == LAST);
        if (ld && !ctl.mst)  adv = ADV_LOAD;
        else if (!ctl.en)    adv = ADV_HOLD;
        else if (ext_mode)   adv = sync_rise ? ADV_WRAP : (at_last ? ADV_HOLD : ADV_STEP);
        else                 adv = at_last ? ADV_WRAP : ADV_STEP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            now       <= '0;
            cyc_start <= 1'b0;
        end else begin
            case (adv)
                ADV_LOAD: now <= ld_time;
                ADV_STEP: now.offset <= now.offset + 1'b1;
                ADV_WRAP: begin
                    now.offset <= '0;
                    now.count  <= now.count + 1'b1;
                end
                default:  now <= now;
            endcase
            cyc_start <= (adv == ADV_WRAP) && ctl.mst && is_root;
        end
    end

    // R2
    offset_range_chk: assert property (@(posedge clk) disable iff (rst)
        now.offset <= LAST);
    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.en && !ext_mode && at_last && !(ld && !ctl.mst)) |=>
        (now.offset == 0 && now.count == $past(now.count) + 1'b1));
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.en && !ld) |=> $stable(now));
    // R5
    ext_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (ext_mode && ctl.en && at_last && !sync_rise) |=> (now.offset == LAST));
    // R7
    start_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_start |-> (now.offset == 0));
endmodule

// File: rtl/cyc_timer_top.sv
module cyc_timer_top
    import cyc_timer_pkg::*;
#(
    parameter int TICKS       = TICKS_DEF,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             ctl_set,
    input  logic             ctl_clr,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    input  logic             is_root,
    input  logic             ext_sync,
    input  logic             too_long,
    input  logic             fault_ack,
    output logic             fault_flag,
    input  logic             rx_load,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [OFF_W-1:0] rx_offset,
    output logic [CNT_W-1:0] cycle_count,
    output logic [OFF_W-1:0] cycle_offset,
    output logic             cycle_start
);
    ctl_t   ctl;
    ctime_t now;
    ctime_t rx_time;
    logic   sync_rise;

    assign rx_time.count  = rx_count;
    assign rx_time.offset = rx_offset;

    cyc_ctl_reg u_ctl (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .set_wr   (ctl_set),
        .clr_wr   (ctl_clr),
        .wdata    (ctl_wdata),
        .tl_evt   (too_long),
        .tl_ack   (fault_ack),
        .ctl      (ctl),
        .flag     (fault_flag)
    );

    cyc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (ext_sync),
        .rise     (sync_rise)
    );

    cyc_offset_ctr #(.TICKS(TICKS)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .sync_rise (sync_rise),
        .is_root   (is_root),
        .ld        (rx_load),
        .ld_time   (rx_time),
        .now       (now),
        .cyc_start (cycle_start)
    );

    assign ctl_rdata    = ctl_pack(ctl);
    assign cycle_count  = now.count;
    assign cycle_offset = now.offset;

    // R7
    start_needs_root_chk: assert property (@(posedge clk) disable iff (rst)
        cycle_start |-> ($past(is_root) && $past(ctl.mst)));
endmodule

// File: tb/sim_cyc_timer_top.sv
module sim_cyc_timer_top;
    logic        clk = 1'b0;
    logic        rst, soft_rst, ctl_set, ctl_clr, is_root, ext_sync;
    logic        too_long, fault_ack, rx_load, fault_flag, cycle_start;
    logic [2:0]  ctl_wdata, ctl_rdata;
    logic [12:0] rx_count, cycle_count;
    logic [11:0] rx_offset, cycle_offset;
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 1'b0;

    always #5 clk = ~clk;

    cyc_timer_top u0 (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .ctl_set(ctl_set), .ctl_clr(ctl_clr),
        .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .is_root(is_root), .ext_sync(ext_sync),
        .too_long(too_long), .fault_ack(fault_ack), .fault_flag(fault_flag),
        .rx_load(rx_load), .rx_count(rx_count), .rx_offset(rx_offset),
        .cycle_count(cycle_count), .cycle_offset(cycle_offset), .cycle_start(cycle_start)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_set(input logic [2:0] d);
        ctl_set = 1'b1; ctl_wdata = d;
        tick(1);
        ctl_set = 1'b0; ctl_wdata = '0;
    endtask

    task automatic wr_clr(input logic [2:0] d);
        ctl_clr = 1'b1; ctl_wdata = d;
        tick(1);
        ctl_clr = 1'b0; ctl_wdata = '0;
    endtask

    task automatic run_to_last();
        for (int i = 0; i < 4000 && cycle_offset != 12'd3071; i++) tick(1);
    endtask

    task automatic hw_reset();
        rst = 1'b1; tick(2); rst = 1'b0;
    endtask

    task automatic t_reset();
        hw_reset();
        check("R1 offset", cycle_offset, 0);
        check("R1 count", cycle_count, 0);
        check("R1 ctl", ctl_rdata, 0);
        check("R1 flag", fault_flag, 0);
        check("R1 start", cycle_start, 0);
    endtask

    task automatic t_internal();
        wr_set(3'b001);
        check("R9 set enable", ctl_rdata, 1);
        check("R2 offset before step", cycle_offset, 0);
        tick(3071);
        check("R2 offset at last", cycle_offset, 3071);
        check("R2 count before wrap", cycle_count, 0);
        tick(1);
        check("R2 offset wrap", cycle_offset, 0);
        check("R2 count step", cycle_count, 1);
        check("R7 no start when slave", cycle_start, 0);
    endtask

    task automatic t_disable();
        int o;
        wr_clr(3'b001);
        check("R9 clear enable", ctl_rdata, 0);
        o = cycle_offset;
        tick(10);
        check("R3 offset held", cycle_offset, o);
        check("R3 count held", cycle_count, 1);
    endtask

    task automatic t_set_clr_same();
        ctl_set = 1'b1; ctl_clr = 1'b1; ctl_wdata = 3'b100;
        tick(1);
        ctl_set = 1'b0; ctl_clr = 1'b0; ctl_wdata = '0;
        check("R9 clear wins", ctl_rdata, 0);
    endtask

    task automatic t_load_wrap();
        rx_load = 1'b1; rx_count = 13'd8191; rx_offset = 12'd3071;
        tick(1);
        rx_load = 1'b0;
        check("R8 load offset", cycle_offset, 3071);
        check("R8 load count", cycle_count, 8191);
        wr_set(3'b001);
        check("R8 held until enabled", cycle_offset, 3071);
        tick(1);
        check("R4 count wrap", cycle_count, 0);
        check("R4 offset wrap", cycle_offset, 0);
    endtask

    task automatic t_master();
        int o;
        is_root = 1'b1;
        wr_set(3'b010);
        check("R9 set master", ctl_rdata, 3);
        o = cycle_offset;
        rx_load = 1'b1; rx_count = 13'd100; rx_offset = 12'd2000;
        tick(1);
        rx_load = 1'b0;
        check("R8 load ignored as master", cycle_offset, o + 1);
        run_to_last();
        tick(1);
        check("R7 start pulse", cycle_start, 1);
        check("R7 offset zero", cycle_offset, 0);
        check("R2 count after master wrap", cycle_count, 1);
        tick(1);
        check("R7 single cycle", cycle_start, 0);
        is_root = 1'b0;
        run_to_last();
        tick(1);
        check("R7 no start when not root", cycle_start, 0);
        check("R7 wrap without root", cycle_offset, 0);
        is_root = 1'b1;
    endtask

    task automatic t_external();
        int c;
        int o;
        wr_set(3'b100);
        check("R9 set source", ctl_rdata, 7);
        run_to_last();
        c = cycle_count;
        tick(5);
        check("R5 hold at last", cycle_offset, 3071);
        check("R5 count held", cycle_count, c);
        ext_sync = 1'b1;
        tick(2);
        check("R5 still waiting", cycle_offset, 3071);
        tick(1);
        check("R5 sync rollover", cycle_offset, 0);
        check("R5 sync count", cycle_count, c + 1);
        check("R7 start on sync", cycle_start, 1);
        tick(5);
        check("R5 no retrigger", cycle_offset, 5);
        ext_sync = 1'b0;
        tick(3);
        check("R5 fall ignored", cycle_offset, 8);
        ext_sync = 1'b1;
        o = cycle_offset;
        tick(2);
        check("R5 early counting", cycle_offset, o + 2);
        tick(1);
        check("R5 early rollover", cycle_offset, 0);
        check("R5 early count", cycle_count, c + 2);
        tick(3);
        ext_sync = 1'b0;
        tick(3);
    endtask

    task automatic t_source_ignored();
        int o;
        wr_clr(3'b010);
        check("R9 clear master", ctl_rdata, 5);
        run_to_last();
        tick(1);
        check("R6 internal wrap", cycle_offset, 0);
        ext_sync = 1'b1;
        o = cycle_offset;
        tick(4);
        check("R6 sync ignored", cycle_offset, o + 4);
        ext_sync = 1'b0;
    endtask

    task automatic t_fault();
        wr_set(3'b010);
        check("R10 master on", ctl_rdata, 7);
        too_long = 1'b1; tick(1); too_long = 1'b0;
        check("R10 master dropped", ctl_rdata, 5);
        check("R10 flag set", fault_flag, 1);
        wr_set(3'b010);
        check("R10 set blocked", ctl_rdata, 5);
        fault_ack = 1'b1; tick(1); fault_ack = 1'b0;
        check("R10 flag cleared", fault_flag, 0);
        wr_set(3'b010);
        check("R10 set after ack", ctl_rdata, 7);
    endtask

    task automatic t_resets();
        soft_rst = 1'b1; tick(1); soft_rst = 1'b0;
        check("R11 soft keeps source", ctl_rdata, 4);
        hw_reset();
        check("R11 hard clears source", ctl_rdata, 0);
        check("R1 offset after reset", cycle_offset, 0);
    endtask

    initial begin
        rst = 1'b1; soft_rst = 1'b0; ctl_set = 1'b0; ctl_clr = 1'b0; ctl_wdata = '0;
        is_root = 1'b0; ext_sync = 1'b0; too_long = 1'b0; fault_ack = 1'b0;
        rx_load = 1'b0; rx_count = '0; rx_offset = '0;
        tick(1);
        t_reset();
        t_internal();
        t_disable();
        t_set_clr_same();
        t_load_wrap();
        t_master();
        t_external();
        t_source_ignored();
        t_fault();
        t_resets();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule